// File: doc/BRIEF.md
# DMA Channel Control and Interrupt Registers

This block is the register front end that sits in front of each channel of a descriptor-driven DMA engine. It turns 32-bit memory-mapped reads and writes into per-channel register operations. Each channel has a set of descriptor pointer registers, a configuration word, a command word, a stream-command word and an interrupt mask. The block also keeps each channel's run state (reset, stopped or running) and builds the status word from that state and from two engine inputs. Each channel drives one level-sensitive interrupt line.

The transfer engine sees this block only through single-cycle request strobes: continue, load data descriptor, load context descriptor and start. The engine feeds back an end-of-list flag, a stream-source code and a set-interrupt vector per channel. Fetching descriptors and moving data belong to the engine, not to this block. An access that does not enable all four bytes is rejected, and an error pulse reports it.

Top module: `dma_chan_regs`

## Requirements
- R1: The channel is `bus_addr >> 13`, and the register is selected by `bus_addr[7:2]`, so bits [12:8] alias. Byte offsets:
  - pointer registers: data pointer 0x00, saved descriptor 0x58, saved buffer 0x5C, group 0x60, group-down 0x7C
  - command 0x80, config 0x84, status 0x88
  - interrupt mask 0x8C, acknowledge 0x90, raw interrupt 0x94, masked interrupt 0x98
  - stream command 0x9C
- R2: Each channel's five pointer registers return the last full-word value written to them, independently of the other channels. Read data for any register appears on `bus_rdata` in the cycle after the read is accepted.
- R3: The channel state is one-hot: reset = 3'b001, stopped = 3'b010, running = 3'b100. After reset every channel is in the reset state and every register reads 0.
- R4: A config write with bit 1 set forces stopped. A config write with bit 0 clear forces reset, and this takes priority over bit 1. A start request moves the state to running only while config bit 0 = 1 and bit 1 = 0.
- R5: The status word holds the state in [2:0], the channel's end-of-list input in bit 5 and its stream-source input in [8 +: SRC_W]. All other bits are 0.
- R6: An acknowledge write clears the raw interrupt bits that are set in the written value. The acknowledge register always reads 0. A set-interrupt bit from the engine in the same cycle survives the clear.
- R7: masked = raw AND mask. The channel's `irq` is high exactly when masked is nonzero. Both update on the clock edge of a mask write, an acknowledge write or a set-interrupt input.
- R8: A stream-command write stores bits [9:0], and those bits read back.
  - Any bit of 0x140 pulses load-data.
  - Bit 0x20 together with a 0x140 bit also pulses start.
  - Any bit of 0x200 pulses load-context.
  - Bit 0x20 alone pulses nothing.
- R9: A command write is stored and pulses continue for one cycle. If any bit above bit 0 is set, `bus_err` also pulses, and continue is still issued.
- R10: An access with `bus_be` other than 4'hF pulses `bus_err` and changes no state. A rejected read returns 0.
- R11: Writes to status, raw interrupt, masked interrupt and unmapped offsets are ignored. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write request, one cycle per access |
| bus_rd | input | 1 | Read request, one cycle per access |
| bus_addr | input | ADDR_W | Byte address |
| bus_be | input | 4 | Byte enables; all four must be set |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after the read |
| bus_err | output | 1 | Error pulse for a rejected access or invalid command bits |
| eng_set_intr | input | NUM_CH*INTR_W | Per-channel interrupt bits to set |
| eng_eol | input | NUM_CH | Per-channel end-of-list flag for status |
| eng_src | input | NUM_CH*SRC_W | Per-channel stream-source code for status |
| irq | output | NUM_CH | Level interrupt per channel |
| cont_req | output | NUM_CH | Continue strobe |
| ld_data_req | output | NUM_CH | Load-data-descriptor strobe |
| ld_ctx_req | output | NUM_CH | Load-context-descriptor strobe |
| start_req | output | NUM_CH | Start strobe |

## Verification
An acknowledge write and an engine set-interrupt event can land on the same raw interrupt bit in the same cycle. The bench provokes this by driving the set-interrupt lane of a channel during the cycle it writes that same bit to the acknowledge register. It then judges the result in two ways: the interrupt line must stay high at the next sample, and a raw-interrupt read must still show the bit. A second collision is also covered: a mask write that enables a bit the engine has already raised must assert the interrupt on that same edge.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;

  localparam int WIN_SHIFT    = 13;
  localparam int SCMD_W       = 10;
  localparam int STAT_EOL_BIT = 5;
  localparam int STAT_SRC_LSB = 8;
  localparam int PTR_SLOT_W   = 3;

  localparam logic [SCMD_W-1:0] SCMD_LOAD_DATA = 10'h140;
  localparam logic [SCMD_W-1:0] SCMD_BURST     = 10'h020;
  localparam logic [SCMD_W-1:0] SCMD_LOAD_CTX  = 10'h200;

  typedef enum logic [2:0] {
    CH_RESET = 3'b001,
    CH_STOP  = 3'b010,
    CH_RUN   = 3'b100
  } chan_state_e;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_DPTR, SEL_SDESC, SEL_SBUF, SEL_GROUP, SEL_GDOWN,
    SEL_CMD, SEL_CFG, SEL_STAT, SEL_MASK, SEL_ACK, SEL_RAW,
    SEL_MASKED, SEL_SCMD
  } reg_sel_e;

  // word index (byte offset / 4) to register select
  function automatic reg_sel_e sel_of_word(input logic [5:0] w);
    case (w)
      6'd0:    return SEL_DPTR;
      6'd22:   return SEL_SDESC;
      6'd23:   return SEL_SBUF;
      6'd24:   return SEL_GROUP;
      6'd31:   return SEL_GDOWN;
      6'd32:   return SEL_CMD;
      6'd33:   return SEL_CFG;
      6'd34:   return SEL_STAT;
      6'd35:   return SEL_MASK;
      6'd36:   return SEL_ACK;
      6'd37:   return SEL_RAW;
      6'd38:   return SEL_MASKED;
      6'd39:   return SEL_SCMD;
      default: return SEL_NONE;
    endcase
  endfunction

  function automatic logic is_ptr(input reg_sel_e s);
    return s inside {SEL_DPTR, SEL_SDESC, SEL_SBUF, SEL_GROUP, SEL_GDOWN};
  endfunction

  function automatic logic [PTR_SLOT_W-1:0] ptr_slot(input reg_sel_e s);
    case (s)
      SEL_SDESC: return 3'd1;
      SEL_SBUF:  return 3'd2;
      SEL_GROUP: return 3'd3;
      SEL_GDOWN: return 3'd4;
      default:   return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/dma_addr_decode.sv
module dma_addr_decode
  import dma_regs_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 15,
  parameter int CH_W   = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        be,
  output logic [CH_W-1:0]   ch,
  output reg_sel_e          sel,
  output logic              bad
);

  localparam int CHF_W = ADDR_W - WIN_SHIFT;

  logic [CHF_W-1:0] ch_raw;
  logic             unused_addr_bits;

  assign ch_raw           = addr[ADDR_W-1:WIN_SHIFT];
  assign ch               = CH_W'(ch_raw);
  assign sel              = sel_of_word(addr[7:2]);
  assign bad              = (be != 4'hF) || (int'(ch_raw) >= NUM_CH);
  assign unused_addr_bits = ^{addr[WIN_SHIFT-1:8], addr[1:0]};

endmodule

// File: rtl/dma_ptr_store.sv
module dma_ptr_store #(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2,
  parameter int SLOT_W = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CH_W-1:0]   wr_ch,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [CH_W-1:0]   rd_ch,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [DATA_W-1:0] rd_data
);

  localparam int IDX_W = CH_W + SLOT_W;
  localparam int DEPTH = NUM_CH << SLOT_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  written;
  logic [DATA_W-1:0] mem_q;
  logic              hit_q;
  logic [IDX_W-1:0]  wr_idx, rd_idx;

  assign wr_idx = {wr_ch, wr_slot};
  assign rd_idx = {rd_ch, rd_slot};

  // plain synchronous RAM, no reset, so it maps onto block memory
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
    if (rd_en) mem_q <= mem[rd_idx];
  end

  // per-entry written flag gives reset-to-zero read behaviour
  always_ff @(posedge clk) begin
    if (rst) begin
      written <= '0;
      hit_q   <= 1'b0;
    end else begin
      if (wr_en) written[wr_idx] <= 1'b1;
      if (rd_en) hit_q <= written[rd_idx];
    end
  end

  assign rd_data = hit_q ? mem_q : '0;

endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
  import dma_regs_pkg::*;
#(
  parameter int INTR_W = 4,
  parameter int SRC_W  = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_cfg,
  input  logic              wr_cmd,
  input  logic              wr_mask,
  input  logic              wr_ack,
  input  logic              wr_scmd,
  input  logic [DATA_W-1:0] wdata,
  input  logic [INTR_W-1:0] set_intr,
  input  logic              eol_in,
  input  logic [SRC_W-1:0]  src_in,
  output logic [DATA_W-1:0] cfg_q,
  output logic [DATA_W-1:0] cmd_q,
  output logic [INTR_W-1:0] mask_q,
  output logic [INTR_W-1:0] raw_q,
  output logic [INTR_W-1:0] masked_q,
  output logic [SCMD_W-1:0] scmd_q,
  output logic [DATA_W-1:0] status_w,
  output logic              irq,
  output logic              cont_req,
  output logic              ld_data_req,
  output logic              ld_ctx_req,
  output logic              start_req
);

  chan_state_e       state_q, state_d;
  logic [INTR_W-1:0] ack_bits, raw_d, mask_d;
  logic [SCMD_W-1:0] scmd_bits;
  logic              want_data, want_start, want_ctx;

  assign scmd_bits  = wdata[SCMD_W-1:0];
  assign want_data  = wr_scmd && |(scmd_bits & SCMD_LOAD_DATA);
  assign want_start = want_data && |(scmd_bits & SCMD_BURST);
  assign want_ctx   = wr_scmd && |(scmd_bits & SCMD_LOAD_CTX);

  always_comb begin
    ack_bits = wr_ack ? wdata[INTR_W-1:0] : '0;
    mask_d   = wr_mask ? wdata[INTR_W-1:0] : mask_q;
    // a new engine event in the same cycle survives the acknowledge
    raw_d    = (raw_q & ~ack_bits) | set_intr;
    state_d  = state_q;
    if (wr_cfg) begin
      if (wdata[1])  state_d = CH_STOP;
      if (!wdata[0]) state_d = CH_RESET;
    end else if (want_start && cfg_q[0] && !cfg_q[1]) begin
      state_d = CH_RUN;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= CH_RESET;
      cfg_q       <= '0;
      cmd_q       <= '0;
      mask_q      <= '0;
      raw_q       <= '0;
      masked_q    <= '0;
      scmd_q      <= '0;
      irq         <= 1'b0;
      cont_req    <= 1'b0;
      ld_data_req <= 1'b0;
      ld_ctx_req  <= 1'b0;
      start_req   <= 1'b0;
    end else begin
      state_q     <= state_d;
      if (wr_cfg)  cfg_q  <= wdata;
      if (wr_cmd)  cmd_q  <= wdata;
      if (wr_scmd) scmd_q <= scmd_bits;
      mask_q      <= mask_d;
      raw_q       <= raw_d;
      masked_q    <= raw_d & mask_d;
      irq         <= |(raw_d & mask_d);
      cont_req    <= wr_cmd;
      ld_data_req <= want_data;
      ld_ctx_req  <= want_ctx;
      start_req   <= want_start;
    end
  end

  always_comb begin
    status_w = '0;
    status_w[2:0] = state_q;
    status_w[STAT_EOL_BIT] = eol_in;
    status_w[STAT_SRC_LSB +: SRC_W] = src_in;
  end

  assert_state_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    $countones(state_q) == 1);

  assert_cfg_reset_prio_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_cfg && !wdata[0]) |=> (state_q == CH_RESET));

  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (rst)
    wr_ack |=> ((raw_q & $past(wdata[INTR_W-1:0]) & ~$past(set_intr)) == '0));

  assert_set_raises_irq_R7: assert property (@(posedge clk) disable iff (rst)
    ((|(set_intr & mask_q)) && !wr_mask) |=> irq);

  assert_scmd_no_data_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_scmd && !(|(wdata[SCMD_W-1:0] & SCMD_LOAD_DATA))) |=> (!ld_data_req && !start_req));

  assert_cmd_continue_R9: assert property (@(posedge clk) disable iff (rst)
    wr_cmd |=> cont_req);

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_regs_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int INTR_W = 4,
  parameter int SRC_W  = 2,
  parameter int DATA_W = 32,
  parameter int ADDR_W = WIN_SHIFT + $clog2(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [3:0]               bus_be,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [DATA_W-1:0]        bus_rdata,
  output logic                     bus_err,
  input  logic [NUM_CH*INTR_W-1:0] eng_set_intr,
  input  logic [NUM_CH-1:0]        eng_eol,
  input  logic [NUM_CH*SRC_W-1:0]  eng_src,
  output logic [NUM_CH-1:0]        irq,
  output logic [NUM_CH-1:0]        cont_req,
  output logic [NUM_CH-1:0]        ld_data_req,
  output logic [NUM_CH-1:0]        ld_ctx_req,
  output logic [NUM_CH-1:0]        start_req
);

  localparam int CH_W = $clog2(NUM_CH);

  logic [CH_W-1:0] dec_ch;
  reg_sel_e        dec_sel;
  logic            dec_bad;
  logic            wr_ok, rd_ok, sel_ptr;

  dma_addr_decode #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CH_W(CH_W)
  ) u_dec (
    .addr(bus_addr), .be(bus_be), .ch(dec_ch), .sel(dec_sel), .bad(dec_bad)
  );

  assign wr_ok   = bus_wr && !dec_bad;
  assign rd_ok   = bus_rd && !bus_wr && !dec_bad;
  assign sel_ptr = is_ptr(dec_sel);

  logic [DATA_W-1:0] mem_rd;

  dma_ptr_store #(
    .NUM_CH(NUM_CH), .CH_W(CH_W), .SLOT_W(PTR_SLOT_W), .DATA_W(DATA_W)
  ) u_ptr (
    .clk(clk), .rst(rst),
    .wr_en(wr_ok && sel_ptr), .wr_ch(dec_ch), .wr_slot(ptr_slot(dec_sel)), .wr_data(bus_wdata),
    .rd_en(rd_ok && sel_ptr), .rd_ch(dec_ch), .rd_slot(ptr_slot(dec_sel)), .rd_data(mem_rd)
  );

  logic [DATA_W-1:0] cfg_a    [NUM_CH];
  logic [DATA_W-1:0] cmd_a    [NUM_CH];
  logic [DATA_W-1:0] stat_a   [NUM_CH];
  logic [INTR_W-1:0] mask_a   [NUM_CH];
  logic [INTR_W-1:0] raw_a    [NUM_CH];
  logic [INTR_W-1:0] masked_a [NUM_CH];
  logic [SCMD_W-1:0] scmd_a   [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    logic hit;
    assign hit = wr_ok && (dec_ch == CH_W'(g));

    dma_chan_ctl #(
      .INTR_W(INTR_W), .SRC_W(SRC_W), .DATA_W(DATA_W)
    ) u_ctl (
      .clk(clk), .rst(rst),
      .wr_cfg (hit && dec_sel == SEL_CFG),
      .wr_cmd (hit && dec_sel == SEL_CMD),
      .wr_mask(hit && dec_sel == SEL_MASK),
      .wr_ack (hit && dec_sel == SEL_ACK),
      .wr_scmd(hit && dec_sel == SEL_SCMD),
      .wdata(bus_wdata),
      .set_intr(eng_set_intr[g*INTR_W +: INTR_W]),
      .eol_in(eng_eol[g]),
      .src_in(eng_src[g*SRC_W +: SRC_W]),
      .cfg_q(cfg_a[g]), .cmd_q(cmd_a[g]), .mask_q(mask_a[g]),
      .raw_q(raw_a[g]), .masked_q(masked_a[g]), .scmd_q(scmd_a[g]),
      .status_w(stat_a[g]),
      .irq(irq[g]), .cont_req(cont_req[g]), .ld_data_req(ld_data_req[g]),
      .ld_ctx_req(ld_ctx_req[g]), .start_req(start_req[g])
    );
  end

  logic [DATA_W-1:0] ctl_val, ctl_q;
  logic              from_mem_q;

  always_comb begin
    case (dec_sel)
      SEL_CMD:    ctl_val = cmd_a[dec_ch];
      SEL_CFG:    ctl_val = cfg_a[dec_ch];
      SEL_STAT:   ctl_val = stat_a[dec_ch];
      SEL_MASK:   ctl_val = DATA_W'(mask_a[dec_ch]);
      SEL_RAW:    ctl_val = DATA_W'(raw_a[dec_ch]);
      SEL_MASKED: ctl_val = DATA_W'(masked_a[dec_ch]);
      SEL_SCMD:   ctl_val = DATA_W'(scmd_a[dec_ch]);
      default:    ctl_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q      <= '0;
      from_mem_q <= 1'b0;
      bus_err    <= 1'b0;
    end else begin
      bus_err <= (bus_wr || bus_rd) &&
                 (dec_bad || (bus_wr && dec_sel == SEL_CMD && |bus_wdata[DATA_W-1:1]));
      if (rd_ok) begin
        ctl_q      <= ctl_val;
        from_mem_q <= sel_ptr;
      end else if (bus_rd) begin
        ctl_q      <= '0;
        from_mem_q <= 1'b0;
      end
    end
  end

  assign bus_rdata = from_mem_q ? mem_rd : ctl_q;

  assert_narrow_err_R10: assert property (@(posedge clk) disable iff (rst)
    ((bus_wr || bus_rd) && bus_be != 4'hF) |=> bus_err);

  assert_narrow_no_strobe_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_be != 4'hF) |=> (cont_req == '0 && ld_data_req == '0 &&
                                    ld_ctx_req == '0 && start_req == '0));

endmodule

// File: tb/sim_dma_chan_regs.sv
module sim_dma_chan_regs;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 20;

  logic        clk = 1'b0;
  logic        rst;
  logic        bus_wr, bus_rd;
  logic [14:0] bus_addr;
  logic [3:0]  bus_be;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic [15:0] eng_set_intr;
  logic [3:0]  eng_eol;
  logic [7:0]  eng_src;
  logic [3:0]  irq, cont_req, ld_data_req, ld_ctx_req, start_req;

  int n_tests = 0;
  int n_fail  = 0;

  logic [31:0] cap_rdata;
  logic        cap_err;
  logic [3:0]  cap_irq, cap_cont, cap_ldd, cap_ldc, cap_st;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_regs u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .eng_set_intr(eng_set_intr), .eng_eol(eng_eol), .eng_src(eng_src), .irq(irq),
    .cont_req(cont_req), .ld_data_req(ld_data_req), .ld_ctx_req(ld_ctx_req),
    .start_req(start_req)
  );

  // {write, requirement number, address, data, expected read value}
  localparam logic [84:0] VECS [NV] = '{
    {1'b1, 4'd2,  16'h2058, 32'hAAAA0001, 32'h0},          // R2 pointer write ch1
    {1'b0, 4'd2,  16'h2058, 32'h0,        32'hAAAA0001},   // R2
    {1'b1, 4'd2,  16'h007C, 32'h12345678, 32'h0},          // R2 group-down ch0
    {1'b0, 4'd2,  16'h007C, 32'h0,        32'h12345678},   // R2
    {1'b0, 4'd2,  16'h0058, 32'h0,        32'h0},          // R2 other channel untouched
    {1'b0, 4'd1,  16'h2F58, 32'h0,        32'hAAAA0001},   // R1 bits [12:8] alias
    {1'b1, 4'd4,  16'h4084, 32'h1,        32'h0},          // R4 enable, no stop
    {1'b0, 4'd5,  16'h4088, 32'h0,        32'h321},        // R5 reset state + eol + src
    {1'b1, 4'd4,  16'h409C, 32'h60,       32'h0},          // R4 start while enabled
    {1'b0, 4'd4,  16'h4088, 32'h0,        32'h324},        // R4 running
    {1'b1, 4'd4,  16'h4084, 32'h3,        32'h0},          // R4 stop bit
    {1'b0, 4'd4,  16'h4088, 32'h0,        32'h322},        // R4 stopped
    {1'b1, 4'd4,  16'h4084, 32'h2,        32'h0},          // R4 bit0 clear wins
    {1'b0, 4'd4,  16'h4088, 32'h0,        32'h321},        // R4 reset
    {1'b1, 4'd8,  16'h409C, 32'hFFFFFFFF, 32'h0},          // R8 wide stream word
    {1'b0, 4'd8,  16'h409C, 32'h0,        32'h3FF},        // R8 only [9:0] kept
    {1'b0, 4'd4,  16'h4088, 32'h0,        32'h321},        // R4 no start while disabled
    {1'b1, 4'd11, 16'h4004, 32'hFFFFFFFF, 32'h0},          // R11 unmapped write
    {1'b0, 4'd11, 16'h4004, 32'h0,        32'h0},          // R11 unmapped reads 0
    {1'b0, 4'd4,  16'h4084, 32'h0,        32'h2}           // R4 config readback
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic capture();
    cap_rdata = bus_rdata; cap_err = bus_err; cap_irq = irq;
    cap_cont = cont_req; cap_ldd = ld_data_req; cap_ldc = ld_ctx_req; cap_st = start_req;
  endtask

  task automatic do_write(input logic [15:0] a, input logic [31:0] d,
                          input logic [3:0] b, input logic [15:0] setv);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a[14:0]; bus_wdata = d; bus_be = b; eng_set_intr = setv;
    @(negedge clk);
    capture();
    bus_wr = 1'b0; bus_be = 4'hF; eng_set_intr = '0;
  endtask

  task automatic do_read(input logic [15:0] a, input logic [3:0] b);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a[14:0]; bus_be = b;
    @(negedge clk);
    capture();
    bus_rd = 1'b0; bus_be = 4'hF;
  endtask

  task automatic pulse_set(input logic [15:0] setv);
    @(negedge clk);
    eng_set_intr = setv;
    @(negedge clk);
    capture();
    eng_set_intr = '0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_be = 4'hF;
    bus_wdata = '0; eng_set_intr = '0; eng_eol = '0; eng_src = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R3 reset state
    do_read(16'h0088, 4'hF); chk("R3 reset status ch0", cap_rdata, 32'h1);
    chk("R3 reset irq", {28'h0, cap_irq}, 32'h0);
    do_read(16'h0058, 4'hF); chk("R3 reset pointer", cap_rdata, 32'h0);
    do_read(16'h4084, 4'hF); chk("R3 reset config", cap_rdata, 32'h0);

    // ch2 engine status inputs: eol set, source = 3
    eng_eol = 4'b0100; eng_src = 8'b0011_0000;

    for (int i = 0; i < NV; i++) begin
      if (VECS[i][84]) begin
        do_write(VECS[i][79:64], VECS[i][63:32], 4'hF, 16'h0);
        chk($sformatf("R%0d row %0d write err", VECS[i][83:80], i), {31'h0, cap_err}, 32'h0);
      end else begin
        do_read(VECS[i][79:64], 4'hF);
        chk($sformatf("R%0d row %0d read", VECS[i][83:80], i), cap_rdata, VECS[i][31:0]);
      end
    end

    // interrupt path, channel 1
    do_write(16'h208C, 32'h5, 4'hF, 16'h0);  chk("R7 mask write irq low", {28'h0, cap_irq}, 32'h0);
    pulse_set(16'h0040);                      chk("R7 set raises irq", {28'h0, cap_irq}, 32'h2);
    do_read(16'h2094, 4'hF);                  chk("R7 raw", cap_rdata, 32'h4);
    do_read(16'h2098, 4'hF);                  chk("R7 masked", cap_rdata, 32'h4);
    do_write(16'h2090, 32'h4, 4'hF, 16'h0);  chk("R6 ack drops irq", {28'h0, cap_irq}, 32'h0);
    do_read(16'h2090, 4'hF);                  chk("R6 ack reads 0", cap_rdata, 32'h0);
    do_read(16'h2094, 4'hF);                  chk("R6 raw cleared", cap_rdata, 32'h0);
    pulse_set(16'h0020);                      chk("R7 masked-off bit no irq", {28'h0, cap_irq}, 32'h0);
    do_read(16'h2098, 4'hF);                  chk("R7 masked zero", cap_rdata, 32'h0);
    do_write(16'h208C, 32'h2, 4'hF, 16'h0);  chk("R7 mask enables pending", {28'h0, cap_irq}, 32'h2);
    do_write(16'h2090, 32'h2, 4'hF, 16'h0020); chk("R6 set beats ack irq", {28'h0, cap_irq}, 32'h2);
    do_read(16'h2094, 4'hF);                  chk("R6 set beats ack raw", cap_rdata, 32'h2);
    do_write(16'h2094, 32'h0, 4'hF, 16'h0);
    do_read(16'h2094, 4'hF);                  chk("R11 raw read-only", cap_rdata, 32'h2);
    do_write(16'h2090, 32'h2, 4'hF, 16'h0);  chk("R6 final ack", {28'h0, cap_irq}, 32'h0);

    // stream-command and command strobes, channel 3
    do_write(16'h609C, 32'h100, 4'hF, 16'h0);
    chk("R8 0x100 load data", {28'h0, cap_ldd, cap_ldc, cap_st} >> 0, {24'h0, 4'h8, 4'h0} << 4);
    do_write(16'h609C, 32'h200, 4'hF, 16'h0);
    chk("R8 0x200 load ctx", {20'h0, cap_ldd, cap_ldc, cap_st}, {20'h0, 4'h0, 4'h8, 4'h0});
    do_write(16'h609C, 32'h020, 4'hF, 16'h0);
    chk("R8 0x020 alone", {20'h0, cap_ldd, cap_ldc, cap_st}, 32'h0);
    do_write(16'h609C, 32'h060, 4'hF, 16'h0);
    chk("R8 0x060 load+start", {20'h0, cap_ldd, cap_ldc, cap_st}, {20'h0, 4'h8, 4'h0, 4'h8});
    do_write(16'h609C, 32'h340, 4'hF, 16'h0);
    chk("R8 0x340 both loads", {20'h0, cap_ldd, cap_ldc, cap_st}, {20'h0, 4'h8, 4'h8, 4'h0});
    do_write(16'h6080, 32'h1, 4'hF, 16'h0);
    chk("R9 continue", {27'h0, cap_err, cap_cont}, {27'h0, 1'b0, 4'h8});
    do_write(16'h6080, 32'h3, 4'hF, 16'h0);
    chk("R9 invalid bits", {27'h0, cap_err, cap_cont}, {27'h0, 1'b1, 4'h8});
    do_read(16'h6080, 4'hF);                  chk("R9 command stored", cap_rdata, 32'h3);

    // narrow accesses
    do_write(16'h0084, 32'h3, 4'h3, 16'h0);  chk("R10 narrow write err", {31'h0, cap_err}, 32'h1);
    do_read(16'h0088, 4'hF);                  chk("R10 state unchanged", cap_rdata, 32'h1);
    do_read(16'h0084, 4'hF);                  chk("R10 config unchanged", cap_rdata, 32'h0);
    do_read(16'h2058, 4'h1);
    chk("R10 narrow read", {cap_rdata[30:0], cap_err}, 32'h1);

    finish_run();
  end

endmodule